// File: doc/BRIEF.md
# Queued I2C Command Sequencer

This block is an I2C bus master that runs whole transactions from a queue. Software loads packed command entries into a command FIFO and then pulses a go control. The engine takes entries one at a time. Each entry may ask for any mix of four steps: a START condition, a nine-clock byte transfer, a STOP condition and a return to idle. When an entry asks for several steps, they run in a fixed order.

Every byte transfer shifts out eight data bits and a ninth acknowledge bit, all MSB first. It samples the bus on the same nine clocks and pushes the byte it read and the acknowledge level it saw into a response FIFO. The engine takes a new command only when the response FIFO has room, so a full response FIFO holds the remaining commands in place until software drains it. An entry can also ask for processing to halt when the slave answers with a NACK.

Both lines are open drain. The block only ever pulls a line low, and a released line is assumed to be pulled high outside the block. Bus timing comes from a quarter-period count derived from the system and bus clock frequencies, with defaults of 100 MHz and 400 kHz. There is no clock stretching and no arbitration between masters.

Top module: `i2c_cmd_sequencer`

## Requirements
- R1: After reset the engine state is IDLE (code 0), both FIFO counts are 0, both depth outputs read FIFO_DEPTH (128), and neither line is pulled low.
- R2: A command entry carries the data byte in bits 7:0 and the transmitted acknowledge level in bit 8. Its step flags are bit 16 START, bit 17 byte transfer, bit 18 STOP, bit 19 return to idle and bit 20 halt on NACK. A write to a full command FIFO is dropped, so the count stays at 128.
- R3: The engine stays IDLE while commands are queued until `go` is pulsed. The cycle after `go`, its state is RUN (code 1).
- R4: The steps of one entry run in the order START, byte, STOP, idle. The state reads START (2), DATA (3) or STOP (4) while a step runs and RUN (1) between steps.
- R5: A byte step drives data bit 7 first and the acknowledge bit last, pulling SDA low for a 0. The response entry holds the sampled byte in bits 7:0 and the sampled ninth bit in bit 8. With SDA looped back, the response equals the command's byte and acknowledge bit.
- R6: SDA changes only while SCL is held low, except at a START (SDA falls while SCL is released) and at a STOP (SDA rises while SCL is released).
- R7: The quarter period is QTR = SYS_HZ/(4*BUS_HZ) cycles. Within a byte, each SCL high time lasts exactly 2*QTR cycles.
- R8: While the response FIFO holds FIFO_DEPTH entries, no command is taken. Processing resumes once software reads a response.
- R9: A pulse on `clr_fifos` empties both FIFOs by the next cycle.
- R10: With halt on NACK set, a sampled acknowledge of 1 returns the engine to IDLE after the response is pushed, and later entries stay queued. Without that flag, processing continues.
- R11: The return-to-idle flag sends the engine to IDLE after the other steps of its entry, and later entries stay queued.
- R12: While running, an empty command FIFO keeps the engine in RUN, and entries written later are processed without a new `go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr_en | input | 1 | Write one command entry |
| cmd_wr_data | input | 21 | Packed command entry |
| rsp_rd_en | input | 1 | Remove the head response entry |
| rsp_rd_data | output | 9 | Head response entry: byte in 7:0, acknowledge in 8 |
| go | input | 1 | Start processing from IDLE |
| clr_fifos | input | 1 | Empty both FIFOs |
| cmd_depth | output | CW | Command FIFO capacity |
| cmd_count | output | CW | Command FIFO fill level |
| rsp_depth | output | CW | Response FIFO capacity |
| rsp_count | output | CW | Response FIFO fill level |
| eng_state | output | 3 | Engine state code |
| scl_o | output | 1 | SCL output level, always 0 |
| scl_oe | output | 1 | Pull SCL low |
| sda_o | output | 1 | SDA output level, always 0 |
| sda_oe | output | 1 | Pull SDA low |
| sda_i | input | 1 | SDA line level as seen on the bus |

## Verification
Each result has its own due time. FIFO counts and the clear take effect one cycle after the strobe, and RUN appears one cycle after `go`. A START or STOP step lasts 4*QTR cycles, a byte step lasts 36*QTR cycles, and RUN adds one or two cycles between steps. Because the queue length varies from test to test, the bench does not count cycles for whole transactions. It waits until the state has rested in IDLE, or in RUN with nothing it can take, for a window longer than any gap between steps, and only then reads counts, responses and the logged state sequence. The SCL high time and the START and STOP conditions are measured edge by edge with counters in the bench.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  localparam int unsigned CMD_W    = 21;
  localparam int unsigned FLG_BASE = 16;
  localparam int unsigned ENT_W    = 14;
  localparam int unsigned RSP_W    = 9;
  // compressed entry layout held in the command FIFO
  localparam int unsigned E_ACK    = 8;
  localparam int unsigned E_START  = 9;
  localparam int unsigned E_DATA   = 10;
  localparam int unsigned E_STOP   = 11;
  localparam int unsigned E_IDLE   = 12;
  localparam int unsigned E_ABORT  = 13;

  typedef enum logic [2:0] {
    ENG_IDLE  = 3'd0,
    ENG_RUN   = 3'd1,
    ENG_START = 3'd2,
    ENG_DATA  = 3'd3,
    ENG_STOP  = 3'd4
  } eng_state_e;

  typedef enum logic [1:0] {
    STEP_START = 2'd0,
    STEP_DATA  = 2'd1,
    STEP_STOP  = 2'd2
  } step_kind_e;

  function automatic int unsigned qtr_ticks(int unsigned sys_hz, int unsigned bus_hz);
    int unsigned q;
    q = sys_hz / (4 * bus_hz);
    return (q < 1) ? 1 : q;
  endfunction

  function automatic logic [RSP_W-1:0] rsp_pack(logic [7:0] byte_v, logic ack_v);
    return {ack_v, byte_v};
  endfunction

  // SDA pull-low level during the setup quarter of a step
  function automatic logic setup_low(step_kind_e k, logic bit_v);
    case (k)
      STEP_START: return 1'b0;
      STEP_STOP:  return 1'b1;
      default:    return ~bit_v;
    endcase
  endfunction
endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       full,
  output logic                       empty
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/i2cq_step_unit.sv
module i2cq_step_unit
  import i2cq_pkg::*;
#(
  parameter int unsigned QTR = 62
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  step_kind_e       kind,
  input  logic [8:0]       tx9,
  input  logic             sda_i,
  output logic             done,
  output logic [8:0]       rx9,
  output logic             scl_low,
  output logic             sda_low,
  output logic             cond_edge
);
  localparam int unsigned TW = $clog2(QTR + 1);

  logic          busy;
  logic [TW-1:0] tcnt;
  logic [1:0]    phase;
  logic [3:0]    bitn;
  logic [8:0]    txs;
  step_kind_e    kind_q;
  logic          tick;

  assign tick = busy && (tcnt == TW'(QTR - 1));

  // quarters: 0 SCL low/hold SDA, 1 SCL low/setup SDA, 2 SCL high, 3 SCL high/final SDA
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      tcnt      <= '0;
      phase     <= 2'd0;
      bitn      <= 4'd0;
      txs       <= '0;
      rx9       <= '0;
      kind_q    <= STEP_START;
      scl_low   <= 1'b0;
      sda_low   <= 1'b0;
      cond_edge <= 1'b0;
      done      <= 1'b0;
    end else begin
      done      <= 1'b0;
      cond_edge <= 1'b0;
      if (go && !busy) begin
        busy    <= 1'b1;
        tcnt    <= '0;
        phase   <= 2'd0;
        bitn    <= 4'd0;
        txs     <= tx9;
        kind_q  <= kind;
        scl_low <= 1'b1;
      end else if (busy) begin
        tcnt <= tick ? '0 : tcnt + TW'(1);
        if (tick) begin
          case (phase)
            2'd0: begin
              phase   <= 2'd1;
              sda_low <= setup_low(kind_q, txs[8]);
            end
            2'd1: begin
              phase   <= 2'd2;
              scl_low <= 1'b0;
            end
            2'd2: begin
              phase <= 2'd3;
              if (kind_q == STEP_DATA) begin
                rx9 <= {rx9[7:0], sda_i};
              end else begin
                sda_low   <= (kind_q == STEP_START);
                cond_edge <= 1'b1;
              end
            end
            default: begin
              phase <= 2'd0;
              if (kind_q == STEP_DATA && bitn != 4'd8) begin
                bitn    <= bitn + 4'd1;
                txs     <= {txs[7:0], 1'b0};
                scl_low <= 1'b1;
              end else begin
                busy <= 1'b0;
                done <= 1'b1;
              end
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2cq_engine.sv
module i2cq_engine
  import i2cq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ENT_W-1:0]  cmd_head,
  input  logic              cmd_empty,
  input  logic              rsp_full,
  input  logic              step_done,
  input  logic [8:0]        rx9,
  output logic              cmd_pop,
  output logic              rsp_push,
  output logic [RSP_W-1:0]  rsp_data,
  output logic              step_go,
  output step_kind_e        step_kind,
  output logic [8:0]        step_tx,
  output logic              abort_hit,
  output eng_state_e        state
);
  logic [3:0] pend;   // 0 start, 1 byte, 2 stop, 3 idle
  logic       abort_q;
  logic [8:0] tx_q;

  always_comb begin
    cmd_pop   = (state == ENG_RUN) && (pend == 4'd0) && !cmd_empty && !rsp_full;
    step_go   = (state == ENG_RUN) && (|pend[2:0]);
    step_kind = pend[0] ? STEP_START : (pend[1] ? STEP_DATA : STEP_STOP);
    step_tx   = tx_q;
    rsp_push  = (state == ENG_DATA) && step_done;
    rsp_data  = rsp_pack(rx9[8:1], rx9[0]);
    abort_hit = rsp_push && abort_q && rx9[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ENG_IDLE;
      pend    <= 4'd0;
      abort_q <= 1'b0;
      tx_q    <= '0;
    end else begin
      case (state)
        ENG_IDLE: if (go) state <= ENG_RUN;
        ENG_RUN: begin
          if (cmd_pop) begin
            pend    <= {cmd_head[E_IDLE], cmd_head[E_STOP], cmd_head[E_DATA], cmd_head[E_START]};
            abort_q <= cmd_head[E_ABORT];
            tx_q    <= {cmd_head[7:0], cmd_head[E_ACK]};
          end else if (pend[0]) begin
            state <= ENG_START;
          end else if (pend[1]) begin
            state <= ENG_DATA;
          end else if (pend[2]) begin
            state <= ENG_STOP;
          end else if (pend[3]) begin
            pend  <= 4'd0;
            state <= ENG_IDLE;
          end
        end
        ENG_START: if (step_done) begin
          pend[0] <= 1'b0;
          state   <= ENG_RUN;
        end
        ENG_DATA: if (step_done) begin
          if (abort_hit) begin
            pend  <= 4'd0;
            state <= ENG_IDLE;
          end else begin
            pend[1] <= 1'b0;
            state   <= ENG_RUN;
          end
        end
        ENG_STOP: if (step_done) begin
          pend[2] <= 1'b0;
          state   <= ENG_RUN;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_cmd_sequencer.sv
module i2c_cmd_sequencer
  import i2cq_pkg::*;
#(
  parameter int unsigned SYS_HZ     = 100_000_000,
  parameter int unsigned BUS_HZ     = 400_000,
  parameter int unsigned FIFO_DEPTH = 128,
  localparam int unsigned CW        = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr_en,
  input  logic [CMD_W-1:0]  cmd_wr_data,
  input  logic              rsp_rd_en,
  output logic [RSP_W-1:0]  rsp_rd_data,
  input  logic              go,
  input  logic              clr_fifos,
  output logic [CW-1:0]     cmd_depth,
  output logic [CW-1:0]     cmd_count,
  output logic [CW-1:0]     rsp_depth,
  output logic [CW-1:0]     rsp_count,
  output logic [2:0]        eng_state,
  output logic              scl_o,
  output logic              scl_oe,
  output logic              sda_o,
  output logic              sda_oe,
  input  logic              sda_i
);
  localparam int unsigned QTR = qtr_ticks(SYS_HZ, BUS_HZ);

  logic [ENT_W-1:0] cmd_ent, cmd_head;
  logic             cmd_full, cmd_empty, cmd_pop;
  logic             rsp_full, rsp_empty, rsp_push;
  logic [RSP_W-1:0] rsp_data;
  logic             step_go, step_done, abort_hit, cond_edge;
  step_kind_e       step_kind;
  logic [8:0]       step_tx, rx9;
  eng_state_e       state;
  logic             reserved_unused;

  // bits 15:9 of a command carry nothing; only 14 bits are stored
  assign cmd_ent         = {cmd_wr_data[CMD_W-1:FLG_BASE], cmd_wr_data[8:0]};
  assign reserved_unused = ^{cmd_wr_data[FLG_BASE-1:9], cmd_full, rsp_empty};

  assign cmd_depth = CW'(FIFO_DEPTH);
  assign rsp_depth = CW'(FIFO_DEPTH);
  assign eng_state = state;
  assign scl_o     = 1'b0;
  assign sda_o     = 1'b0;

  i2cq_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) cmd_fifo_i (
    .clk(clk), .rst_n(rst_n), .clr(clr_fifos),
    .push(cmd_wr_en), .push_data(cmd_ent), .pop(cmd_pop),
    .head(cmd_head), .count(cmd_count), .full(cmd_full), .empty(cmd_empty)
  );

  i2cq_fifo #(.W(RSP_W), .DEPTH(FIFO_DEPTH)) rsp_fifo_i (
    .clk(clk), .rst_n(rst_n), .clr(clr_fifos),
    .push(rsp_push), .push_data(rsp_data), .pop(rsp_rd_en),
    .head(rsp_rd_data), .count(rsp_count), .full(rsp_full), .empty(rsp_empty)
  );

  i2cq_engine engine_i (
    .clk(clk), .rst_n(rst_n), .go(go),
    .cmd_head(cmd_head), .cmd_empty(cmd_empty), .rsp_full(rsp_full),
    .step_done(step_done), .rx9(rx9),
    .cmd_pop(cmd_pop), .rsp_push(rsp_push), .rsp_data(rsp_data),
    .step_go(step_go), .step_kind(step_kind), .step_tx(step_tx),
    .abort_hit(abort_hit), .state(state)
  );

  i2cq_step_unit #(.QTR(QTR)) step_i (
    .clk(clk), .rst_n(rst_n), .go(step_go), .kind(step_kind),
    .tx9(step_tx), .sda_i(sda_i), .done(step_done), .rx9(rx9),
    .scl_low(scl_oe), .sda_low(sda_oe), .cond_edge(cond_edge)
  );
endmodule

// File: rtl/i2cq_checker.sv
module i2cq_checker #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned CW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go,
  input logic          clr_fifos,
  input logic [2:0]    eng_state,
  input logic [CW-1:0] cmd_count,
  input logic [CW-1:0] rsp_count,
  input logic          scl_low,
  input logic          sda_low,
  input logic          cond_edge,
  input logic          cmd_pop,
  input logic          rsp_full,
  input logic          rsp_push,
  input logic          abort_hit
);
  p_cmd_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_count <= CW'(DEPTH));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_state == 3'd0 && !go) |=> eng_state == 3'd0);

  p_go_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_state == 3'd0 && go) |=> eng_state == 3'd1);

  p_sda_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_low) |-> ((scl_low && $past(scl_low)) || cond_edge));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_full |-> !cmd_pop);

  p_push_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_push |-> !rsp_full);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fifos |=> (cmd_count == '0 && rsp_count == '0));

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit |=> eng_state == 3'd0);
endmodule

bind i2c_cmd_sequencer i2cq_checker #(.DEPTH(FIFO_DEPTH), .CW(CW)) checker_i (
  .clk(clk), .rst_n(rst_n), .go(go), .clr_fifos(clr_fifos),
  .eng_state(eng_state), .cmd_count(cmd_count), .rsp_count(rsp_count),
  .scl_low(scl_oe), .sda_low(sda_oe), .cond_edge(cond_edge),
  .cmd_pop(cmd_pop), .rsp_full(rsp_full), .rsp_push(rsp_push),
  .abort_hit(abort_hit)
);

// File: tb/i2c_cmd_sequencer_tb_top.sv
module i2c_cmd_sequencer_tb_top;
  localparam int SYS = 3_200_000;
  localparam int BUS = 400_000;
  localparam int TQ  = SYS / (BUS * 4);
  localparam int DEP = 128;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_wr_en = 1'b0, rsp_rd_en = 1'b0, go = 1'b0, clr_fifos = 1'b0;
  logic [20:0] cmd_wr_data = '0;
  logic [8:0]  rsp_rd_data;
  logic [7:0]  cmd_depth, cmd_count, rsp_depth, rsp_count;
  logic [2:0]  eng_state;
  logic        scl_o, scl_oe, sda_o, sda_oe, sda_i;
  logic        dev_pull = 1'b0;

  int n_checks = 0, n_errors = 0;
  int start_cnt = 0, stop_cnt = 0, hi_len = 0, min_hi = 1_000_000;
  int slog [64];
  int slog_n = 0;
  logic       p_scl = 1'b1, p_sda = 1'b1;
  logic [2:0] p_st = 3'd0;

  always #10 clk = ~clk;

  assign sda_i = !(sda_oe || dev_pull);

  i2c_cmd_sequencer #(.SYS_HZ(SYS), .BUS_HZ(BUS), .FIFO_DEPTH(DEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data),
    .rsp_rd_en(rsp_rd_en), .rsp_rd_data(rsp_rd_data), .go(go), .clr_fifos(clr_fifos),
    .cmd_depth(cmd_depth), .cmd_count(cmd_count), .rsp_depth(rsp_depth),
    .rsp_count(rsp_count), .eng_state(eng_state), .scl_o(scl_o), .scl_oe(scl_oe),
    .sda_o(sda_o), .sda_oe(sda_oe), .sda_i(sda_i)
  );

  // bus monitor: START/STOP conditions, SCL high time, state changes
  always @(posedge clk) begin
    if (rst_n) begin
      if (p_scl && !scl_oe && p_sda && sda_oe) start_cnt++;
      if (p_scl && !scl_oe && !p_sda && !sda_oe) stop_cnt++;
      if (!scl_oe) hi_len++;
      else begin
        if (p_scl && hi_len < min_hi) min_hi = hi_len;
        hi_len = 0;
      end
      if (eng_state != p_st && slog_n < 64) begin
        slog[slog_n] = int'(eng_state);
        slog_n++;
      end
    end
    p_scl = !scl_oe;
    p_sda = !sda_oe;
    p_st  = eng_state;
  end

  function automatic logic [20:0] mk(int d, int a, int st, int dt, int sp, int idl, int ab);
    logic [20:0] e;
    e = '0;
    e[7:0] = d[7:0];
    e[8]   = a[0];
    e[16]  = st[0];
    e[17]  = dt[0];
    e[18]  = sp[0];
    e[19]  = idl[0];
    e[20]  = ab[0];
    return e;
  endfunction

  function automatic int exp_rsp(int d, int a, bit pulled);
    return pulled ? 0 : ((a & 1) * 256 + (d & 255));
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_log(string tag, int n, int exp_seq [8]);
    int bad = 0;
    n_checks++;
    if (slog_n != n) bad = 1;
    for (int i = 0; i < n && i < slog_n; i++) if (slog[i] != exp_seq[i]) bad = 1;
    if (bad) begin
      n_errors++;
      $display("FAIL %s actual_len=%0d first=%0d expected_len=%0d first=%0d",
               tag, slog_n, slog[0], n, exp_seq[0]);
    end
  endtask

  task automatic push(logic [20:0] e);
    cmd_wr_en = 1'b1; cmd_wr_data = e;
    @(negedge clk);
    cmd_wr_en = 1'b0;
  endtask

  task automatic pulse_go();
    go = 1'b1; @(negedge clk); go = 1'b0;
  endtask

  task automatic pulse_clr();
    clr_fifos = 1'b1; @(negedge clk); clr_fifos = 1'b0;
  endtask

  task automatic pop(output int v);
    v = int'(rsp_rd_data);
    rsp_rd_en = 1'b1; @(negedge clk); rsp_rd_en = 1'b0;
  endtask

  task automatic settle();
    int quiet = 0;
    int guard = 0;
    while (quiet < 12 && guard < 60000) begin
      @(negedge clk);
      guard++;
      if (eng_state == 3'd0 ||
          (eng_state == 3'd1 && (cmd_count == 0 || rsp_count == 8'(DEP)))) quiet++;
      else quiet = 0;
    end
    if (guard >= 60000) chk("settle timeout", 1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    int v, s0, p0;
    int dv [12];
    int av [12];
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 state", int'(eng_state), 0);
    chk("R1 cmd_count", int'(cmd_count), 0);
    chk("R1 rsp_count", int'(rsp_count), 0);
    chk("R1 cmd_depth", int'(cmd_depth), DEP);
    chk("R1 rsp_depth", int'(rsp_depth), DEP);
    chk("R1 lines released", int'({scl_oe, sda_oe}), 0);

    // R3 idle until go
    push(mk(8'h5A, 1, 0, 1, 0, 0, 0));
    repeat (40) @(negedge clk);
    chk("R3 idle holds", int'(eng_state), 0);
    chk("R3 entry waits", int'(cmd_count), 1);
    pulse_clr();
    chk("R9 clear cmd", int'(cmd_count), 0);

    // R4 R6 R5 combined entry
    slog_n = 0; s0 = start_cnt; p0 = stop_cnt; min_hi = 1_000_000;
    push(mk(8'hC3, 1, 1, 1, 1, 0, 0));
    pulse_go();
    chk("R3 go gives RUN", int'(eng_state), 1);
    settle();
    chk_log("R4 step order", 7, '{1, 2, 1, 3, 1, 4, 1, 0});
    chk("R6 start count", start_cnt - s0, 1);
    chk("R6 stop count", stop_cnt - p0, 1);
    chk("R6 bus released", int'({scl_oe, sda_oe}), 0);
    chk("R5 rsp count", int'(rsp_count), 1);
    pop(v);
    chk("R5 loopback rsp", v, exp_rsp(8'hC3, 1, 0));
    chk("R7 scl high", min_hi, 2 * TQ);

    // R5 R12 random bytes while running
    for (int k = 0; k < 12; k++) begin
      dv[k] = int'($urandom % 256);
      av[k] = int'($urandom % 2);
      push(mk(dv[k], av[k], (k == 0), 1, (k == 11), 0, 0));
    end
    settle();
    chk("R12 still running", int'(eng_state), 1);
    chk("R12 all taken", int'(cmd_count), 0);
    chk("R5 rsp count random", int'(rsp_count), 12);
    for (int k = 0; k < 12; k++) begin
      pop(v);
      chk("R5 random rsp", v, exp_rsp(dv[k], av[k], 0));
    end

    // R5 slave holding SDA low
    dev_pull = 1'b1;
    push(mk(8'hA5, 1, 0, 1, 0, 0, 0));
    settle();
    pop(v);
    chk("R5 pulled rsp", v, exp_rsp(8'hA5, 1, 1));
    dev_pull = 1'b0;

    // R10 halt on NACK
    push(mk(8'h81, 1, 0, 1, 0, 0, 1));
    push(mk(8'h3C, 0, 0, 1, 0, 0, 0));
    settle();
    chk("R10 halted", int'(eng_state), 0);
    chk("R10 left queued", int'(cmd_count), 1);
    chk("R10 rsp pushed", int'(rsp_count), 1);
    pop(v);
    chk("R10 nack rsp", v, exp_rsp(8'h81, 1, 0));
    pulse_go();
    settle();
    chk("R10 resumed", int'(cmd_count), 0);
    pop(v);
    chk("R10 later rsp", v, exp_rsp(8'h3C, 0, 0));
    push(mk(8'h7E, 1, 0, 1, 0, 0, 0));
    push(mk(8'h11, 0, 0, 1, 0, 0, 0));
    settle();
    chk("R10 no halt flag continues", int'(eng_state), 1);
    chk("R10 both rsp", int'(rsp_count), 2);
    pop(v);
    pop(v);
    chk("R10 second rsp", v, exp_rsp(8'h11, 0, 0));

    // R11 return-to-idle flag
    slog_n = 0;
    push(mk(8'h66, 0, 1, 1, 1, 1, 0));
    push(mk(0, 0, 1, 0, 0, 0, 0));
    settle();
    chk("R11 idle", int'(eng_state), 0);
    chk("R11 left queued", int'(cmd_count), 1);
    chk_log("R11 order", 7, '{2, 1, 3, 1, 4, 1, 0, 0});
    pop(v);
    chk("R11 rsp", v, exp_rsp(8'h66, 0, 0));
    pulse_clr();

    // R2 drop when full, R8 back-pressure, R9 clear
    for (int i = 0; i < DEP + 1; i++) push(mk(i % 256, i & 1, 0, 1, 0, 0, 0));
    chk("R2 full drop", int'(cmd_count), DEP);
    pulse_go();
    settle();
    chk("R8 rsp full", int'(rsp_count), DEP);
    chk("R8 cmd drained", int'(cmd_count), 0);
    for (int i = 0; i < 4; i++) push(mk(8'hF0 + i, 1, 0, 1, 0, 0, 0));
    settle();
    chk("R8 held", int'(cmd_count), 4);
    chk("R8 rsp still full", int'(rsp_count), DEP);
    pop(v);
    chk("R8 first rsp", v, exp_rsp(0, 0, 0));
    pop(v);
    chk("R8 second rsp", v, exp_rsp(1, 1, 0));
    settle();
    chk("R8 resumed two", int'(cmd_count), 2);
    chk("R8 refilled", int'(rsp_count), DEP);
    pulse_clr();
    chk("R9 cmd cleared", int'(cmd_count), 0);
    chk("R9 rsp cleared", int'(rsp_count), 0);

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule